// File: doc/BRIEF.md
# Modem Status Change Register

This block holds the modem status byte of a 16550-style serial port. Four external modem lines pass through a synchronizer into a line-state nibble in bits 7:4. Bits 3:0 hold a latched change flag for each line. A flag stays set until the host reads the byte. The block also holds the five-bit modem control register. One bit of that register selects an internal loopback, in which the four control outputs replace the external lines.

A pending flag is raised whenever any change flag is set. That flag is gated by a modem-status interrupt enable to form the interrupt request. A read strobe returns the current byte and clears the change flags on the same clock edge. A line change that lands on that same edge is not lost: it shows up in the flags after the clear. Prioritising this request against other interrupt sources is left to the surrounding logic.

Top module: `modem_status_delta`

## Requirements
- R1: After reset, `stat_rdata` reads 0xB0 (DCD, DSR and CTS asserted, RI clear, no flags), `ctl_rdata` reads 0x08 (OUT2 set) and `pending` is low.
- R2: `modem_in` bit 0 is CTS, bit 1 is DSR, bit 2 is RI and bit 3 is DCD. They appear at status bits 4, 5, 6 and 7 respectively. A change driven between edges shows in `stat_rdata` after the third rising edge (two synchronizer stages plus the state register).
- R3: When a line state bit n+4 changes, change flag n (bits 3:0) is set. Flags are ORed with those already latched and never drop without a read.
- R4: The RI change flag (bit 2) is set only when RI goes from 1 to 0. A rise of RI sets no flag.
- R5: `stat_rdata` shows the current byte combinationally. A clock edge with `stat_rd` high clears bits 3:0 and leaves bits 7:4 unchanged.
- R6: A line change that updates the state on the same edge as a read is kept: its flag is set after that edge, not cleared.
- R7: `pending` is high exactly when any of bits 3:0 is set. `irq` equals `pending` AND `msi_en`.
- R8: A write through `ctl_wr` stores `ctl_wdata[4:0]`. `ctl_rdata` returns the stored bits with bits 7:5 read as zero.
- R9: While control bit 4 is set (loopback), the control bits drive the line state: bit 1 (RTS) goes to CTS, bit 0 (DTR) to DSR, bit 2 (OUT1) to RI and bit 3 (OUT2) to DCD. The new state shows after the second edge following the write edge, and the change flags follow R3 and R4.
- R10: While loopback is selected, changes on `modem_in` leave `stat_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| modem_in | input | 4 | Asynchronous modem lines {DCD, RI, DSR, CTS} |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| stat_rd | input | 1 | Status read strobe; clears the change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| stat_rdata | output | 8 | Status byte: line states 7:4, change flags 3:0 |
| ctl_rdata | output | 8 | Control register read value |
| pending | output | 1 | Any change flag set |
| irq | output | 1 | Pending gated by the enable |

## Verification
A wrong line-state register shows up in the upper nibble of the status byte at the third edge after an input change, or at the second edge after a loopback write. It also produces a false flag on the next transition. A flag register that drops a bit without a read, or sets the RI flag on a rise, differs from the expected lower nibble as soon as the state edge has passed. `pending` and `irq` show the same error in the same cycle. A clear that races a line change is exposed on the edge after the read strobe, where the held-over flag must be visible.

// File: rtl/msd_pkg.sv
// Package: shared bit positions and reset values for the modem status change block.
// Assumes line nibble order {DCD, RI, DSR, CTS} matches status bits 7:4.
package msd_pkg;
    localparam int NLINES   = 4;
    localparam int CTL_W    = 5;
    // line nibble positions
    localparam int LN_CTS   = 0;
    localparam int LN_DSR   = 1;
    localparam int LN_RI    = 2;
    localparam int LN_DCD   = 3;
    // control register positions
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;
    localparam int CTL_LOOP = 4;
    localparam logic [NLINES-1:0] LINE_RST  = 4'b1011;
    localparam logic [CTL_W-1:0]  CTL_RST   = 5'b01000;
    // lines whose flag is set only on a 1 -> 0 transition
    localparam logic [NLINES-1:0] TRAIL_MSK = 4'b0100;
endpackage

// File: rtl/msd_sync.sv
// Module: multi-stage synchronizer for asynchronous level inputs.
// Assumes each bit is an independent slow level; no bus coherency is given.
module msd_sync #(
    parameter int                W       = 4,
    parameter int                STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // shift the inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/msd_ctl_reg.sv
// Module: modem control register; keeps only the low CTL_W bits of a write.
// Assumes at most one write strobe per cycle.
module msd_ctl_reg
    import msd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic [CTL_W-1:0] ctl_q
);
    logic [DW-CTL_W-1:0] unused_hi;
    assign unused_hi = wdata[DW-1:CTL_W];

    // store the kept bits of the control byte
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= CTL_RST;
        else if (wr) ctl_q <= wdata[CTL_W-1:0];
    end

    // R8
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ctl_q == $past(wdata[CTL_W-1:0]));
endmodule

// File: rtl/msd_delta.sv
// Module: line state register and sticky change flags with read-clear.
// Assumes line_i is synchronous; a read on a changing edge keeps the new flags.
module msd_delta
    import msd_pkg::*;
#(
    parameter int               N        = NLINES,
    parameter logic [N-1:0]     RST_VAL  = LINE_RST,
    parameter logic [N-1:0]     TRAIL    = TRAIL_MSK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic         rd_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] new_chg;

    // changes this cycle; trailing-only lines ignore rises
    always_comb new_chg = (cur_o ^ line_i) & ~(TRAIL & line_i);

    // track the line state
    always_ff @(posedge clk) begin
        if (!rst_n) cur_o <= RST_VAL;
        else        cur_o <= line_i;
    end

    // latch change flags; a read clears old flags but keeps fresh ones
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= '0;
        else if (rd_i)  flag_o <= new_chg;
        else            flag_o <= flag_o | new_chg;
    end

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (flag_o & $past(flag_o)) == $past(flag_o));
    // R4
    ring_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !cur_o[LN_RI] && line_i[LN_RI]) |=> flag_o[LN_RI] == $past(flag_o[LN_RI]));
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && line_i == cur_o) |=> flag_o == '0);
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ((cur_o ^ line_i) & ~TRAIL) != '0) |=> flag_o != '0);
endmodule

// File: rtl/modem_status_delta.sv
// Module: modem status change register top. Synchronizes the modem lines,
// selects loopback sources, and exposes status, control, pending and irq.
// Assumes a single clock domain for host access; modem_in is asynchronous.
module modem_status_delta
    import msd_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    modem_in,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          stat_rd,
    input  logic          msi_en,
    output logic [DW-1:0] stat_rdata,
    output logic [DW-1:0] ctl_rdata,
    output logic          pending,
    output logic          irq
);
    logic [NLINES-1:0] sync_q;
    logic [NLINES-1:0] loop_src;
    logic [NLINES-1:0] line_src;
    logic [NLINES-1:0] cur_st;
    logic [NLINES-1:0] flags;
    logic [CTL_W-1:0]  ctl_q;

    msd_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(modem_in), .q(sync_q));

    msd_ctl_reg #(.DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .ctl_q(ctl_q));

    // route control outputs to line positions for loopback
    always_comb begin
        loop_src          = '0;
        loop_src[LN_CTS]  = ctl_q[CTL_RTS];
        loop_src[LN_DSR]  = ctl_q[CTL_DTR];
        loop_src[LN_RI]   = ctl_q[CTL_OUT1];
        loop_src[LN_DCD]  = ctl_q[CTL_OUT2];
    end

    // pick the line source: internal loop or synchronized pins
    always_comb line_src = ctl_q[CTL_LOOP] ? loop_src : sync_q;

    msd_delta #(.N(NLINES), .RST_VAL(LINE_RST), .TRAIL(TRAIL_MSK)) u_delta (
        .clk(clk), .rst_n(rst_n), .line_i(line_src), .rd_i(stat_rd),
        .cur_o(cur_st), .flag_o(flags));

    // assemble read values and interrupt outputs
    always_comb begin
        stat_rdata = {{(DW-2*NLINES){1'b0}}, cur_st, flags};
        ctl_rdata  = {{(DW-CTL_W){1'b0}}, ctl_q};
        pending    = |flags;
        irq        = pending & msi_en;
    end

    // R9
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CTL_LOOP] |=> cur_st == $past({ctl_q[CTL_OUT2], ctl_q[CTL_OUT1],
                                             ctl_q[CTL_DTR], ctl_q[CTL_RTS]}));
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msi_en && stat_rdata[NLINES-1:0] != '0));
endmodule

// File: tb/modem_status_delta_test.sv
module modem_status_delta_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] modem_in = 4'b1011;
    logic       ctl_wr = 0;
    logic [7:0] ctl_wdata = 0;
    logic       stat_rd = 0;
    logic       msi_en = 0;
    logic [7:0] stat_rdata, ctl_rdata;
    logic       pending, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // {modem_in, expected status after the change settles}
    localparam logic [11:0] VEC [0:4] = '{12'hAA1, 12'hEE0, 12'hAA4, 12'h55B, 12'hBBE};

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_delta uut (
        .clk(clk), .rst_n(rst_n), .modem_in(modem_in), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .stat_rd(stat_rd), .msi_en(msi_en),
        .stat_rdata(stat_rdata), .ctl_rdata(ctl_rdata), .pending(pending), .irq(irq));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic rd_clear(input string req, input logic [7:0] exp_before);
        stat_rd = 1;
        check(req, stat_rdata, exp_before);
        step(1);
        stat_rd = 0;
        check(req, stat_rdata, {exp_before[7:4], 4'h0});
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v;
        step(1);
        ctl_wr = 0;
        step(1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); step(2);
        rst_n = 1;
        // R1 reset state
        check("R1 status", stat_rdata, 8'hB0);
        check("R1 ctl", ctl_rdata, 8'h08);
        check("R1 pending", {7'b0, pending}, 8'h00);

        // R2 R3 R4 R5 table walk
        for (int i = 0; i < 5; i++) begin
            modem_in = VEC[i][11:8];
            step(3);
            check("R2/R3/R4 vector", stat_rdata, VEC[i][7:0]);
            check("R7 pending", {7'b0, pending}, {7'b0, |VEC[i][3:0]});
            rd_clear("R5 read clear", VEC[i][7:0]);
        end

        // R3 sticky accumulation across two changes
        modem_in = 4'b1010; step(3);
        modem_in = 4'b1011; step(3);
        check("R3 sticky", stat_rdata, 8'hB1);
        // R7 irq gating
        check("R7 irq masked", {7'b0, irq}, 8'h00);
        msi_en = 1; #1;
        check("R7 irq enabled", {7'b0, irq}, 8'h01);
        rd_clear("R5 clear", 8'hB1);
        check("R7 irq after clear", {7'b0, irq}, 8'h00);

        // R6 change coinciding with read
        modem_in = 4'b1010;
        step(2);
        stat_rd = 1;
        check("R6 before", stat_rdata, 8'hB0);
        step(1);
        stat_rd = 0;
        check("R6 held over", stat_rdata, 8'hA1);
        modem_in = 4'b1011; step(3);
        rd_clear("R5 restore", 8'hB1);

        // R9 loopback with all control outputs low
        ctl_write(8'h10);
        check("R9 loop enter", stat_rdata, 8'h0B);
        // R10 external inputs ignored
        modem_in = 4'b0100; step(4);
        check("R10 ignore pins", stat_rdata, 8'h0B);
        rd_clear("R5 loop clear", 8'h0B);
        ctl_write(8'h12);
        check("R9 RTS to CTS", stat_rdata, 8'h11);
        rd_clear("R5", 8'h11);
        ctl_write(8'h1F);
        check("R9/R4 all high", stat_rdata, 8'hFA);
        rd_clear("R5", 8'hFA);
        ctl_write(8'h1B);
        check("R9/R4 OUT1 falls", stat_rdata, 8'hB4);
        check("R8 ctl readback", ctl_rdata, 8'h1B);

        // R8 upper bits dropped; leaving loopback returns to pins
        ctl_write(8'hE8);
        check("R8 ctl mask", ctl_rdata, 8'h08);
        check("R9 loop exit", stat_rdata, 8'h4F);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule